// File: doc/BRIEF.md
# Dual-Strobe EDO DRAM Control Decoder

This block models the control logic that sits on the memory side of a page-mode DRAM with two column strobes, one for each byte. Each clock it samples the row strobe, the two column strobes, the write-enable and output-enable pins, and a 9-bit multiplexed address. From these it works out which kind of memory cycle is running. It then latches the row and column, reads from or writes to a small internal storage array, and drives a separate output-enable for each byte lane of the data bus.

The two column strobes are combined into one internal column strobe. It turns on at the first strobe to fall and turns off only when both strobes are high again. If the merged strobe is already active when the row strobe falls, the cycle is a refresh that uses a row number from an internal counter instead of the address pins. Read data follows extended-data-out rules: it stays on the bus after the column strobe rises, until the next column strobe fall or a condition that puts the bus in high impedance. Every row opening is reported on a refresh strobe output, together with the row number used. The storage array uses only the low address bits, and its size is set by parameters.

All pins are synchronous to `clk`. Every output is registered and changes on the clock edge that samples the pin change that causes it.

Top module: `dram_ctl_decoder`

## Requirements
- R1: The merged column strobe becomes active on the first of `lcas_n`/`ucas_n` to go low and stays active until both are high. The column is latched only on that first fall. A second strobe falling, or one strobe rising and falling again while the other stays low, latches no new column and loads no new data.
- R2: Upper-byte output enable (`dq_oe[1]`) is set only while `ucas_n` is low, and lower-byte output enable (`dq_oe[0]`) only while `lcas_n` is low. A write stores `din[15:8]` only if `ucas_n` is low at the write trigger, and `din[7:0]` only if `lcas_n` is low. The array word is addressed by {row[3:0], col[3:0]} with the default parameters.
- R3: If the merged column strobe is active in the sample where `ras_n` is first seen low, the cycle is a refresh. `rfsh_row` then reports the internal counter value and ignores `addr`.
- R4: During a refresh cycle, `dq_oe` stays 2'b00 and no write takes place, whatever `we_n`, `oe_n` and `din` do.
- R5: A normal row opening (merged column strobe inactive when `ras_n` falls) latches `addr` as the row. It reports that row on `rfsh_row` with a one-cycle `rfsh_pulse`.
- R6: A read is triggered by whichever of the merged-strobe fall and the `oe_n` fall comes later, with `we_n` high. On the trigger edge `dq_o` loads the word at the latched row and column.
- R7: A write is triggered by whichever of the merged-strobe fall and the `we_n` fall comes later. It stores `din` at the latched row and column.
- R8: Read data and its lane enables stay on the bus after the column strobes rise, even after `ras_n` rises. They change only at the next merged-strobe fall.
- R9: The refresh counter is 0 after reset, increments once per refresh cycle, and wraps from 511 to 0.
- R10: `dq_oe` goes to 2'b00 one cycle after `oe_n` is high, after `we_n` is low, or after `ras_n` and both column strobes are high.
- R11: While `rst_n` is low, `dq_oe` is 2'b00 and `rfsh_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower-byte column strobe, active low |
| ucas_n | input | 1 | Upper-byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ROW_W | Multiplexed row/column address |
| din | input | 16 | Write data |
| dq_o | output | 16 | Read data |
| dq_oe | output | 2 | Per-byte output enable, bit 1 upper byte |
| rfsh_pulse | output | 1 | One-cycle pulse on each row opening |
| rfsh_row | output | ROW_W | Row refreshed by that opening |

## Verification
A wrong refresh counter shows up on `rfsh_row` in the cycle after the very next refresh, and a counter that wraps incorrectly shows up after 512 refreshes. A wrong latched column or a wrong merged-strobe state shows up as wrong or stale read data, or as a missing lane enable, on the edge that triggers the read. A write to a wrong location stays hidden until that word is read back later. A bad lane-enable state shows up on `dq_oe` one cycle after the high-impedance or extended-hold condition, so the bench samples it at exactly that cycle.

// File: rtl/dram_ctl_pkg.sv
// Shared types for the DRAM control decoder.
package dram_ctl_pkg;
    // Kind of row cycle currently open.
    typedef enum logic [1:0] {
        CYC_IDLE = 2'd0,
        CYC_ROW  = 2'd1,
        CYC_CBR  = 2'd2
    } cyc_state_e;

    localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/dram_strobe_sync.sv
// Samples the strobe pins, converts them to active-high form, merges the
// per-lane column strobes (first fall / last rise) and finds falling pin edges.
// Assumes all pins are synchronous to clk.
module dram_strobe_sync #(
    parameter int unsigned LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic [LANES-1:0] cas_n,
    input  logic             we_n,
    input  logic             oe_n,
    output logic             ras_act,
    output logic [LANES-1:0] lane_cas,
    output logic             cas_act,
    output logic             we_act,
    output logic             oe_act,
    output logic             ras_fall,
    output logic             cas_fall,
    output logic             we_fall,
    output logic             oe_fall
);
    logic ras_q, cas_q, we_q, oe_q;

    // Active-high views and pin falling edges.
    always_comb begin
        ras_act  = ~ras_n;
        lane_cas = ~cas_n;
        cas_act  = |lane_cas;
        we_act   = ~we_n;
        oe_act   = ~oe_n;
        ras_fall = ras_act & ~ras_q;
        cas_fall = cas_act & ~cas_q;
        we_fall  = we_act  & ~we_q;
        oe_fall  = oe_act  & ~oe_q;
    end

    // Previous-sample registers; reset treats every pin as already active so
    // that no edge is reported before a real high sample has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_q <= 1'b1;
            cas_q <= 1'b1;
            we_q  <= 1'b1;
            oe_q  <= 1'b1;
        end else begin
            ras_q <= ras_act;
            cas_q <= cas_act;
            we_q  <= we_act;
            oe_q  <= oe_act;
        end
    end
endmodule

// File: rtl/dram_cycle_ctrl.sv
// Tracks the open row cycle, decides between normal and refresh cycles,
// latches row and column indices and runs the refresh row counter.
// Assumes AR_W <= ROW_W and AC_W <= ROW_W.
module dram_cycle_ctrl
    import dram_ctl_pkg::*;
#(
    parameter int unsigned ROW_W = 9,
    parameter int unsigned AR_W  = 4,
    parameter int unsigned AC_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_act,
    input  logic             cas_act,
    input  logic             ras_fall,
    input  logic             cas_fall,
    input  logic [ROW_W-1:0] addr,
    output cyc_state_e       state,
    output logic [AR_W-1:0]  row_idx,
    output logic [AC_W-1:0]  col_idx,
    output logic             rfsh_pulse,
    output logic [ROW_W-1:0] rfsh_row
);
    logic [ROW_W-1:0] rcnt;
    logic [AC_W-1:0]  col_q;

    // Cycle kind: chosen at the row strobe fall, closed when it rises.
    always_ff @(posedge clk) begin
        if (!rst_n)          state <= CYC_IDLE;
        else if (!ras_act)   state <= CYC_IDLE;
        else if (ras_fall)   state <= cas_act ? CYC_CBR : CYC_ROW;
    end

    // Refresh row counter, advanced once per refresh cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                    rcnt <= '0;
        else if (ras_fall && cas_act)  rcnt <= rcnt + 1'b1;
    end

    // Report every row opening with the row it refreshes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rfsh_pulse <= 1'b0;
            rfsh_row   <= '0;
        end else begin
            rfsh_pulse <= ras_fall;
            if (ras_fall) rfsh_row <= cas_act ? rcnt : addr;
        end
    end

    // Row index latch for normal cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)                     row_idx <= '0;
        else if (ras_fall && !cas_act)  row_idx <= addr[AR_W-1:0];
    end

    // Column latch on the merged strobe fall inside a normal row cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 col_q <= '0;
        else if (cas_fall && state == CYC_ROW)      col_q <= addr[AC_W-1:0];
    end

    // Column in use: live address at the fall, latched value afterwards.
    always_comb col_idx = cas_fall ? addr[AC_W-1:0] : col_q;

    // R9
    cbr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_fall && cas_act) |=> (rcnt == ROW_W'($past(rcnt) + 1'b1)));
endmodule

// File: rtl/dram_array.sv
// Scaled storage array, one bank per byte lane, with per-lane write enable
// and a combinational read. Contents are not reset.
module dram_array
    import dram_ctl_pkg::*;
#(
    parameter int unsigned AR_W  = 4,
    parameter int unsigned AC_W  = 4,
    parameter int unsigned LANES = 2
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [LANES-1:0]        lane_we,
    input  logic [AR_W-1:0]         row_idx,
    input  logic [AC_W-1:0]         col_idx,
    input  logic [LANES*BYTE_W-1:0] wdata,
    output logic [LANES*BYTE_W-1:0] rdata
);
    localparam int unsigned IDX_W = AR_W + AC_W;
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [IDX_W-1:0] idx;
    always_comb idx = {row_idx, col_idx};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] bank [DEPTH];

        // Byte-lane write.
        always_ff @(posedge clk) begin
            if (wr_en && lane_we[g]) bank[idx] <= wdata[g*BYTE_W +: BYTE_W];
        end

        // Byte-lane read.
        always_comb rdata[g*BYTE_W +: BYTE_W] = bank[idx];
    end
endmodule

// File: rtl/dram_out_stage.sv
// Output data register with extended hold and per-lane output enables.
// Assumes clear has priority and rd_go implies rd_ok.
module dram_out_stage
    import dram_ctl_pkg::*;
#(
    parameter int unsigned LANES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_go,
    input  logic                    rd_ok,
    input  logic                    clear,
    input  logic [LANES-1:0]        lane_cas,
    input  logic [LANES*BYTE_W-1:0] rdata,
    output logic [LANES*BYTE_W-1:0] dq_o,
    output logic [LANES-1:0]        dq_oe
);
    // Read data held until the next read trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)     dq_o <= '0;
        else if (rd_go) dq_o <= rdata;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_en
        // Lane enable: cleared, reloaded at a trigger, or joined late.
        always_ff @(posedge clk) begin
            if (!rst_n)                     dq_oe[g] <= 1'b0;
            else if (clear)                 dq_oe[g] <= 1'b0;
            else if (rd_go)                 dq_oe[g] <= lane_cas[g];
            else if (rd_ok && lane_cas[g])  dq_oe[g] <= 1'b1;
        end
    end
endmodule

// File: rtl/dram_ctl_decoder.sv
// Top of the DRAM control decoder: merges strobes, classifies cycles,
// accesses the scaled array and drives per-byte output enables.
// Assumes synchronous pins and a fixed two-lane (16-bit) data bus.
module dram_ctl_decoder
    import dram_ctl_pkg::*;
#(
    parameter int unsigned ROW_W = 9,
    parameter int unsigned AR_W  = 4,
    parameter int unsigned AC_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic             lcas_n,
    input  logic             ucas_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [ROW_W-1:0] addr,
    input  logic [15:0]      din,
    output logic [15:0]      dq_o,
    output logic [1:0]       dq_oe,
    output logic             rfsh_pulse,
    output logic [ROW_W-1:0] rfsh_row
);
    localparam int unsigned LANES = 2;
    localparam int unsigned DW    = LANES * BYTE_W;

    logic             ras_act, cas_act, we_act, oe_act;
    logic             ras_fall, cas_fall, we_fall, oe_fall;
    logic [LANES-1:0] lane_cas;
    cyc_state_e       state;
    logic [AR_W-1:0]  row_idx;
    logic [AC_W-1:0]  col_idx;
    logic [DW-1:0]    rdata;
    logic             rd_ok, rd_go, wr_en, clear;

    dram_strobe_sync #(.LANES(LANES)) strobe_i (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n({ucas_n, lcas_n}),
        .we_n(we_n), .oe_n(oe_n), .ras_act(ras_act), .lane_cas(lane_cas),
        .cas_act(cas_act), .we_act(we_act), .oe_act(oe_act),
        .ras_fall(ras_fall), .cas_fall(cas_fall), .we_fall(we_fall),
        .oe_fall(oe_fall)
    );

    dram_cycle_ctrl #(.ROW_W(ROW_W), .AR_W(AR_W), .AC_W(AC_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .ras_act(ras_act), .cas_act(cas_act),
        .ras_fall(ras_fall), .cas_fall(cas_fall), .addr(addr),
        .state(state), .row_idx(row_idx), .col_idx(col_idx),
        .rfsh_pulse(rfsh_pulse), .rfsh_row(rfsh_row)
    );

    // Access decode: read/write triggers and the high-impedance condition.
    always_comb begin
        rd_ok = (state == CYC_ROW) && cas_act && !we_act && oe_act;
        rd_go = rd_ok && (cas_fall || oe_fall);
        wr_en = (state == CYC_ROW) && cas_act && we_act && (cas_fall || we_fall);
        clear = (!ras_act && !cas_act) || !oe_act || we_act ||
                (state == CYC_CBR) || (ras_fall && cas_act);
    end

    dram_array #(.AR_W(AR_W), .AC_W(AC_W), .LANES(LANES)) array_i (
        .clk(clk), .wr_en(wr_en), .lane_we(lane_cas), .row_idx(row_idx),
        .col_idx(col_idx), .wdata(din), .rdata(rdata)
    );

    dram_out_stage #(.LANES(LANES)) out_i (
        .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .rd_ok(rd_ok), .clear(clear),
        .lane_cas(lane_cas), .rdata(rdata), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    // R4
    cbr_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CYC_CBR) |-> (dq_oe == '0));
    // R10
    oe_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_act |=> (dq_oe == '0));
    // R10
    we_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_act |=> (dq_oe == '0));
    // R10
    idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_act && !cas_act) |=> (dq_oe == '0));
endmodule

// File: tb/dram_ctl_decoder_tb_top.sv
module dram_ctl_decoder_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ras_n, lcas_n, ucas_n, we_n, oe_n;
    logic [8:0]  addr;
    logic [15:0] din;
    logic [15:0] dq_o;
    logic [1:0]  dq_oe;
    logic        rfsh_pulse;
    logic [8:0]  rfsh_row;

    int checks = 0;
    int errors = 0;
    logic [15:0] model [256];
    int cnt_exp = 0;

    // Write vectors: row, column, data, lane mask (bit1 upper, bit0 lower).
    localparam logic [35:0] VEC [8] = '{
        {9'h003, 9'h005, 16'hBEEF, 2'b11},
        {9'h0F1, 9'h1A2, 16'h1234, 2'b11},
        {9'h003, 9'h005, 16'h00AA, 2'b01},
        {9'h0F1, 9'h1A2, 16'h5600, 2'b10},
        {9'h1FF, 9'h1FF, 16'hFFFF, 2'b11},
        {9'h010, 9'h020, 16'h0001, 2'b11},
        {9'h000, 9'h000, 16'h8000, 2'b11},
        {9'h1FF, 9'h1FF, 16'h7E00, 2'b10}
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_ctl_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n),
        .ucas_n(ucas_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din),
        .dq_o(dq_o), .dq_oe(dq_oe), .rfsh_pulse(rfsh_pulse),
        .rfsh_row(rfsh_row)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_pins();
        ras_n = 1'b1; lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    function automatic int idx(input logic [8:0] r, input logic [8:0] c);
        return int'({r[3:0], c[3:0]});
    endfunction

    task automatic do_write(input logic [8:0] r, input logic [8:0] c,
                            input logic [15:0] d, input logic [1:0] lanes);
        idle_pins(); cyc();
        ras_n = 1'b0; addr = r; cyc();
        addr = c; din = d; we_n = 1'b0;
        lcas_n = ~lanes[0]; ucas_n = ~lanes[1]; cyc();
        lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1; cyc();
        ras_n = 1'b1; cyc();
        if (lanes[0]) model[idx(r, c)][7:0]  = d[7:0];
        if (lanes[1]) model[idx(r, c)][15:8] = d[15:8];
    endtask

    task automatic do_read(input logic [8:0] r, input logic [8:0] c,
                           output logic [15:0] q, output logic [1:0] en);
        idle_pins(); cyc();
        ras_n = 1'b0; addr = r; cyc();
        addr = c; oe_n = 1'b0; lcas_n = 1'b0; ucas_n = 1'b0; cyc();
        q = dq_o; en = dq_oe;
        idle_pins(); cyc(); cyc();
    endtask

    task automatic do_cbr(input logic we_low, input logic [8:0] junk);
        idle_pins(); lcas_n = 1'b0; we_n = ~we_low; din = 16'hDEAD;
        addr = junk; cyc();
        ras_n = 1'b0; cyc();
        check("R3 cbr pulse", 32'(rfsh_pulse), 32'd1);
        check("R3 R9 cbr row from counter", 32'(rfsh_row), 32'(cnt_exp));
        check("R4 cbr no drive", 32'(dq_oe), 32'd0);
        cyc();
        check("R4 cbr still no drive", 32'(dq_oe), 32'd0);
        idle_pins(); cyc();
        cnt_exp = (cnt_exp + 1) % 512;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] q;
        logic [1:0]  en;
        logic [15:0] w1, w2;
        rst_n = 1'b0; idle_pins(); addr = '0; din = '0;
        cyc(); cyc(); cyc();
        // R11 reset state
        check("R11 reset oe", 32'(dq_oe), 32'd0);
        check("R11 reset pulse", 32'(rfsh_pulse), 32'd0);
        rst_n = 1'b1; cyc();

        // R2 R6 R7 table walk: write then read back.
        for (int i = 0; i < 8; i++) begin
            do_write(VEC[i][35:27], VEC[i][26:18], VEC[i][17:2], VEC[i][1:0]);
            do_read(VEC[i][35:27], VEC[i][26:18], q, en);
            check("R2 R6 table data", 32'(q), 32'(model[idx(VEC[i][35:27], VEC[i][26:18])]));
            check("R6 table lanes", 32'(en), 32'd3);
        end

        // R5 normal row opening report.
        idle_pins(); cyc();
        ras_n = 1'b0; addr = 9'h155; cyc();
        check("R5 row pulse", 32'(rfsh_pulse), 32'd1);
        check("R5 row value", 32'(rfsh_row), 32'h155);
        cyc();
        check("R5 pulse one cycle", 32'(rfsh_pulse), 32'd0);
        idle_pins(); cyc();

        // R6 late output enable uses latched column.
        do_write(9'h007, 9'h009, 16'hC0DE, 2'b11);
        idle_pins(); cyc();
        ras_n = 1'b0; addr = 9'h007; cyc();
        addr = 9'h009; lcas_n = 1'b0; ucas_n = 1'b0; cyc();
        check("R6 no drive before oe", 32'(dq_oe), 32'd0);
        oe_n = 1'b0; addr = 9'h00E; cyc();
        check("R6 late oe lanes", 32'(dq_oe), 32'd3);
        check("R6 late oe data", 32'(dq_o), 32'hC0DE);
        idle_pins(); cyc();

        // R7 late write enable uses latched column.
        idle_pins(); cyc();
        ras_n = 1'b0; addr = 9'h007; cyc();
        addr = 9'h00A; lcas_n = 1'b0; ucas_n = 1'b0; cyc();
        we_n = 1'b0; din = 16'h4321; addr = 9'h00B; cyc();
        idle_pins(); cyc();
        model[idx(9'h007, 9'h00A)] = 16'h4321;
        do_read(9'h007, 9'h00A, q, en);
        check("R7 late we stored", 32'(q), 32'h4321);
        do_read(9'h007, 9'h00B, q, en);
        check("R7 junk column untouched", 32'(q), 32'(model[idx(9'h007, 9'h00B)]));

        // R1 R2 R8 merged strobe and extended hold.
        w1 = 16'hA55A; w2 = 16'h1B2C;
        do_write(9'h002, 9'h001, w1, 2'b11);
        do_write(9'h002, 9'h006, w2, 2'b11);
        idle_pins(); cyc();
        ras_n = 1'b0; addr = 9'h002; cyc();
        addr = 9'h001; oe_n = 1'b0; lcas_n = 1'b0; cyc();
        check("R2 lower lane only", 32'(dq_oe), 32'd1);
        check("R6 lower byte", 32'(dq_o[7:0]), 32'(w1[7:0]));
        addr = 9'h006; ucas_n = 1'b0; cyc();
        check("R1 R2 upper joins", 32'(dq_oe), 32'd3);
        check("R1 no relatch", 32'(dq_o), 32'(w1));
        lcas_n = 1'b1; cyc();
        check("R1 cas held by upper", 32'(dq_oe), 32'd3);
        lcas_n = 1'b0; cyc();
        check("R1 no new fall", 32'(dq_o), 32'(w1));
        lcas_n = 1'b1; ucas_n = 1'b1; cyc();
        check("R8 hold lanes after cas rise", 32'(dq_oe), 32'd3);
        check("R8 hold data after cas rise", 32'(dq_o), 32'(w1));
        lcas_n = 1'b0; cyc();
        check("R8 R2 next fall lanes", 32'(dq_oe), 32'd1);
        check("R8 next fall data", 32'(dq_o[7:0]), 32'(w2[7:0]));
        idle_pins(); cyc();

        // R10 high-impedance conditions.
        idle_pins(); cyc();
        ras_n = 1'b0; addr = 9'h002; cyc();
        addr = 9'h001; oe_n = 1'b0; lcas_n = 1'b0; ucas_n = 1'b0; cyc();
        check("R10 driving", 32'(dq_oe), 32'd3);
        oe_n = 1'b1; cyc();
        check("R10 oe high", 32'(dq_oe), 32'd0);
        oe_n = 1'b0; cyc();
        check("R10 oe back", 32'(dq_oe), 32'd3);
        din = w1; we_n = 1'b0; cyc();
        check("R10 we low", 32'(dq_oe), 32'd0);
        we_n = 1'b1; cyc();
        ras_n = 1'b1; cyc();
        check("R8 R10 ras high cas low holds", 32'(dq_oe), 32'd3);
        lcas_n = 1'b1; ucas_n = 1'b1; cyc();
        check("R10 all strobes high", 32'(dq_oe), 32'd0);

        // R3 R4 R9 refresh cycles with write attempt, then counter wrap.
        do_write(9'h000, 9'h000, 16'h5A5A, 2'b11);
        do_cbr(1'b1, 9'h1AA);
        do_read(9'h000, 9'h000, q, en);
        check("R4 no write in refresh", 32'(q), 32'h5A5A);
        for (int k = 1; k < 512; k++) do_cbr(1'b0, 9'(k));
        do_cbr(1'b0, 9'h0F0);
        check("R9 wrapped count", 32'(cnt_exp), 32'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule